// File: doc/BRIEF.md
# Fixed-Window 16KB Bank Mapper

This block sits between an 8-bit CPU with a 16-bit logical address and a 1 MiB physical bus. It converts each logical address into a 20-bit physical address. The logical space is cut into four 16KB regions. The lowest region always lands at the bottom of physical memory, which keeps zero page and the stack reachable. The highest region always lands at the top of physical memory, which keeps the vectors and the resident ROM visible. The two middle regions are movable windows. Each window takes its 16KB physical bank number from its own bank register.

Software changes a window by storing a byte to logical `$0000` (first window) or `$0001` (second window). The store takes effect when the phi2 strobe falls. A load from either address returns the bank number. For any access to those two addresses the block raises a register-hit flag, which the board's chip-select logic uses to keep memory off the bus. The physical address is still produced for those two addresses.

No data stream crosses this block. Every pin is a plain level that follows the CPU bus, so there is no valid/ready handshake and no back-pressure. The CPU bus timing acts as the only flow control.

Top module: `bank_mapper`

## Requirements
- R1: Logical addresses `$0000`-`$3FFF` map to physical `{6'b000000, logical[13:0]}` whatever the bank registers hold.
- R2: Logical addresses `$C000`-`$FFFF` map to physical `{6'b111111, logical[13:0]}` (`$FC000`-`$FFFFF`) whatever the bank registers hold.
- R3: Logical addresses `$4000`-`$7FFF` map to physical `{bank_a, logical[13:0]}`, where `bank_a` is the 6-bit register stored at `$0000`.
- R4: Logical addresses `$8000`-`$BFFF` map to physical `{bank_b, logical[13:0]}`, where `bank_b` is the 6-bit register stored at `$0001`.
- R5: A write (`cpu_rw` = 0) to `$0000` or `$0001` loads data bits [5:0] into the selected register at the falling edge of phi2. The address, data and direction used are the ones present while phi2 was high. Data bits [7:6] are ignored.
- R6: A register changes only at a phi2 falling edge that ends a write to `$0000` or `$0001`. A write held with phi2 high does not change the mapping, and a read of a register does not change it either.
- R7: While `reg_hit` is high and `cpu_rw` = 1, `reg_rdata` equals `{2'b00, register}`. At all other times `reg_rdata` is zero.
- R8: `reg_hit` is high for logical `$0000` and `$0001` in both directions and low for every other address. In those two cycles the physical address is `$00000`/`$00001`.
- R9: After reset, `bank_a` = 1 and `bank_b` = 2, so the lower 48KB of logical space maps onto itself.
- R10: A write to any address other than `$0000`/`$0001` (for example `$0002`) leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; phi2 is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | CPU bus phase strobe; a write commits on its falling edge |
| phys_addr | output | 20 | Translated physical address (combinational) |
| reg_hit | output | 1 | Access targets a bank register; memory select must be suppressed |
| reg_rdata | output | 8 | Bank register read-back, zero when not reading a register |

## Verification
On every cycle the bound checker enforces the two fixed regions, the zero read-back outside register reads and the zero upper bits inside them, the low physical address during a register hit, and that the bank registers stay put unless phi2 has just fallen. Whether a committed value is the right one cannot be seen cycle by cycle. The bench's scenarios show this: the reset mapping, the exact physical addresses after programming both windows (including truncation of the upper data bits), and that a write to `$0002`, a register read, or a write held without a phi2 fall leaves the mapping as it was.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int LOG_AW  = 16;
  localparam int PHYS_AW = 20;
  localparam int WIN_AW  = 14;
  localparam int DATA_W  = 8;

  localparam int BANK_W     = PHYS_AW - WIN_AW;
  localparam int REGION_W   = LOG_AW - WIN_AW;
  localparam int NUM_REGION = 1 << REGION_W;
  localparam int NUM_WIN    = NUM_REGION - 2;
  localparam int WSEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  typedef enum logic [1:0] {
    RGN_FIXED_LO = 2'd0,
    RGN_WINDOW   = 2'd1,
    RGN_FIXED_HI = 2'd2
  } rgn_kind_e;
endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
  import bmap_pkg::*;
#(
  parameter int P_LOG_AW  = LOG_AW,
  parameter int P_WIN_AW  = WIN_AW,
  parameter int P_NUM_WIN = NUM_WIN,
  parameter int P_WSEL_W  = WSEL_W
) (
  input  logic [P_LOG_AW-1:0] addr,
  output rgn_kind_e           kind,
  output logic [P_WSEL_W-1:0] win_sel,
  output logic                reg_hit,
  output logic [P_WSEL_W-1:0] reg_sel
);
  localparam int RGN_W  = P_LOG_AW - P_WIN_AW;
  localparam int LAST_R = (1 << RGN_W) - 1;

  logic [RGN_W-1:0] region;
  logic [RGN_W-1:0] win_ofs;

  assign region  = addr[P_LOG_AW-1:P_WIN_AW];
  assign win_ofs = region - RGN_W'(1);

  always_comb begin
    if (region == '0)
      kind = RGN_FIXED_LO;
    else if (region == RGN_W'(LAST_R))
      kind = RGN_FIXED_HI;
    else
      kind = RGN_WINDOW;
  end

  assign win_sel = P_WSEL_W'(win_ofs);
  assign reg_hit = (addr < P_LOG_AW'(P_NUM_WIN));
  assign reg_sel = addr[P_WSEL_W-1:0];
endmodule

// File: rtl/bmap_regs.sv
module bmap_regs
  import bmap_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_BANK_W  = BANK_W,
  parameter int P_NUM_WIN = NUM_WIN,
  parameter int P_WSEL_W  = WSEL_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               phi2,
  input  logic                               reg_hit,
  input  logic [P_WSEL_W-1:0]                reg_sel,
  input  logic                               cpu_rw,
  input  logic [P_DATA_W-1:0]                wdata,
  output logic [P_NUM_WIN-1:0][P_BANK_W-1:0] bank_q
);
  logic                phi2_q;
  logic                cap_hit;
  logic                cap_wr;
  logic [P_WSEL_W-1:0] cap_sel;
  logic [P_BANK_W-1:0] cap_data;
  logic                commit;
  logic                unused_hi_bits;

  assign unused_hi_bits = ^wdata[P_DATA_W-1:P_BANK_W];

  // Bus state is captured every clock while phi2 is high; the last
  // capture is what the falling edge commits.
  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q   <= 1'b0;
      cap_hit  <= 1'b0;
      cap_wr   <= 1'b0;
      cap_sel  <= '0;
      cap_data <= '0;
    end else begin
      phi2_q <= phi2;
      if (phi2) begin
        cap_hit  <= reg_hit;
        cap_wr   <= ~cpu_rw;
        cap_sel  <= reg_sel;
        cap_data <= wdata[P_BANK_W-1:0];
      end
    end
  end

  assign commit = phi2_q & ~phi2 & cap_hit & cap_wr;

  for (genvar w = 0; w < P_NUM_WIN; w++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[w] <= P_BANK_W'(w + 1);
      else if (commit && (cap_sel == P_WSEL_W'(w)))
        bank_q[w] <= cap_data;
    end
  end
endmodule

// File: rtl/bmap_xlate.sv
module bmap_xlate
  import bmap_pkg::*;
#(
  parameter int P_WIN_AW  = WIN_AW,
  parameter int P_BANK_W  = BANK_W,
  parameter int P_NUM_WIN = NUM_WIN,
  parameter int P_WSEL_W  = WSEL_W
) (
  input  rgn_kind_e                          kind,
  input  logic [P_WSEL_W-1:0]                win_sel,
  input  logic [P_WIN_AW-1:0]                offset,
  input  logic [P_NUM_WIN-1:0][P_BANK_W-1:0] bank_q,
  output logic [P_BANK_W+P_WIN_AW-1:0]       phys
);
  logic [P_BANK_W-1:0] bank_sel;

  always_comb begin
    case (kind)
      RGN_FIXED_LO: bank_sel = '0;
      RGN_FIXED_HI: bank_sel = '1;
      default:      bank_sel = bank_q[win_sel];
    endcase
  end

  assign phys = {bank_sel, offset};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bmap_pkg::*;
#(
  parameter int P_LOG_AW  = LOG_AW,
  parameter int P_PHYS_AW = PHYS_AW,
  parameter int P_WIN_AW  = WIN_AW,
  parameter int P_DATA_W  = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [P_LOG_AW-1:0]  cpu_addr,
  input  logic [P_DATA_W-1:0]  cpu_wdata,
  input  logic                 cpu_rw,
  input  logic                 phi2,
  output logic [P_PHYS_AW-1:0] phys_addr,
  output logic                 reg_hit,
  output logic [P_DATA_W-1:0]  reg_rdata
);
  localparam int L_BANK_W  = P_PHYS_AW - P_WIN_AW;
  localparam int L_NUM_WIN = (1 << (P_LOG_AW - P_WIN_AW)) - 2;
  localparam int L_WSEL_W  = (L_NUM_WIN > 1) ? $clog2(L_NUM_WIN) : 1;

  rgn_kind_e                          kind;
  logic [L_WSEL_W-1:0]                win_sel;
  logic [L_WSEL_W-1:0]                reg_sel;
  logic [L_NUM_WIN-1:0][L_BANK_W-1:0] bank_q;

  bmap_decode #(
    .P_LOG_AW(P_LOG_AW), .P_WIN_AW(P_WIN_AW),
    .P_NUM_WIN(L_NUM_WIN), .P_WSEL_W(L_WSEL_W)
  ) u_decode (
    .addr(cpu_addr), .kind(kind), .win_sel(win_sel),
    .reg_hit(reg_hit), .reg_sel(reg_sel)
  );

  bmap_regs #(
    .P_DATA_W(P_DATA_W), .P_BANK_W(L_BANK_W),
    .P_NUM_WIN(L_NUM_WIN), .P_WSEL_W(L_WSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .phi2(phi2), .reg_hit(reg_hit),
    .reg_sel(reg_sel), .cpu_rw(cpu_rw), .wdata(cpu_wdata),
    .bank_q(bank_q)
  );

  bmap_xlate #(
    .P_WIN_AW(P_WIN_AW), .P_BANK_W(L_BANK_W),
    .P_NUM_WIN(L_NUM_WIN), .P_WSEL_W(L_WSEL_W)
  ) u_xlate (
    .kind(kind), .win_sel(win_sel), .offset(cpu_addr[P_WIN_AW-1:0]),
    .bank_q(bank_q), .phys(phys_addr)
  );

  assign reg_rdata = (reg_hit && cpu_rw) ? P_DATA_W'(bank_q[reg_sel]) : '0;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int P_LOG_AW  = 16,
  parameter int P_PHYS_AW = 20,
  parameter int P_WIN_AW  = 14,
  parameter int P_DATA_W  = 8,
  parameter int P_NUM_WIN = 2
) (
  input logic                                       clk,
  input logic                                       rst,
  input logic [P_LOG_AW-1:0]                        cpu_addr,
  input logic                                       cpu_rw,
  input logic                                       phi2,
  input logic [P_PHYS_AW-1:0]                       phys_addr,
  input logic                                       reg_hit,
  input logic [P_DATA_W-1:0]                        reg_rdata,
  input logic [P_NUM_WIN-1:0][P_PHYS_AW-P_WIN_AW-1:0] bank_q
);
  localparam int BW = P_PHYS_AW - P_WIN_AW;
  localparam int RW = P_LOG_AW - P_WIN_AW;

  logic phi2_seen;
  always_ff @(posedge clk) begin
    if (rst) phi2_seen <= 1'b0;
    else     phi2_seen <= phi2;
  end

  // R1
  low_map_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[P_LOG_AW-1:P_WIN_AW] == '0) |->
      (phys_addr == {{BW{1'b0}}, cpu_addr[P_WIN_AW-1:0]}));

  // R2
  high_map_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[P_LOG_AW-1:P_WIN_AW] == {RW{1'b1}}) |->
      (phys_addr == {{BW{1'b1}}, cpu_addr[P_WIN_AW-1:0]}));

  // R8
  hit_phys_chk: assert property (@(posedge clk) disable iff (rst)
    reg_hit |-> (phys_addr < P_PHYS_AW'(P_NUM_WIN)));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_hit && cpu_rw) |-> (reg_rdata == '0));

  // R7
  rdata_upper_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[P_DATA_W-1:BW] == '0);

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(phi2_seen && !phi2) |=> $stable(bank_q));
endmodule

bind bank_mapper bank_mapper_chk #(
  .P_LOG_AW(P_LOG_AW), .P_PHYS_AW(P_PHYS_AW),
  .P_WIN_AW(P_WIN_AW), .P_DATA_W(P_DATA_W), .P_NUM_WIN(L_NUM_WIN)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
  .phi2(phi2), .phys_addr(phys_addr), .reg_hit(reg_hit),
  .reg_rdata(reg_rdata), .bank_q(bank_q)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_rw = 1'b1;
  logic        phi2 = 1'b0;
  logic [19:0] phys_addr;
  logic        reg_hit;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_mapper uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .phi2(phi2), .phys_addr(phys_addr),
    .reg_hit(reg_hit), .reg_rdata(reg_rdata)
  );

  // {logical address, expected physical, expected hit}
  // with bank_a = 6'h2A and bank_b = 6'h3F
  localparam logic [36:0] VEC [11] = '{
    {16'h0000, 20'h00000, 1'b1},
    {16'h0001, 20'h00001, 1'b1},
    {16'h0002, 20'h00002, 1'b0},
    {16'h3FFF, 20'h03FFF, 1'b0},
    {16'h4000, 20'hA8000, 1'b0},
    {16'h5123, 20'hA9123, 1'b0},
    {16'h7FFF, 20'hABFFF, 1'b0},
    {16'h8000, 20'hFC000, 1'b0},
    {16'hBFFF, 20'hFFFFF, 1'b0},
    {16'hC000, 20'hFC000, 1'b0},
    {16'hFFFC, 20'hFFFFC, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw);
    cpu_addr = a; cpu_wdata = d; cpu_rw = rw;
    phi2 = 1'b1;
    repeat (3) @(posedge clk);
    #1 phi2 = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic probe(input logic [15:0] a, input logic rw);
    cpu_addr = a; cpu_rw = rw;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;

    // R9 reset mapping
    probe(16'h4000, 1'b1); check("R9 win1 reset", phys_addr, 20'h04000);
    probe(16'h7FFF, 1'b1); check("R9 win1 top", phys_addr, 20'h07FFF);
    probe(16'h8000, 1'b1); check("R9 win2 reset", phys_addr, 20'h08000);
    probe(16'h0000, 1'b1); check("R9 R7 read reg0", reg_rdata, 8'h01);
    probe(16'h0001, 1'b1); check("R9 R7 read reg1", reg_rdata, 8'h02);

    // R5 program both windows, upper bits dropped on second
    bus_cycle(16'h0000, 8'h2A, 1'b0);
    bus_cycle(16'h0001, 8'hFF, 1'b0);

    // R1 R2 R3 R4 R8 table walk
    foreach (VEC[i]) begin
      probe(VEC[i][36:21], 1'b1);
      check("R1-4 table phys", phys_addr, VEC[i][20:1]);
      check("R8 table hit", reg_hit, VEC[i][0]);
    end

    // R7 readback with upper zero, zero when not a register
    probe(16'h0001, 1'b1); check("R7 R5 read reg1 truncated", reg_rdata, 8'h3F);
    probe(16'h0000, 1'b1); check("R7 read reg0", reg_rdata, 8'h2A);
    probe(16'h4000, 1'b1); check("R7 rdata idle", reg_rdata, 8'h00);
    probe(16'h0000, 1'b0); check("R8 hit on write", reg_hit, 1'b1);
    check("R7 rdata zero on write", reg_rdata, 8'h00);

    // R6 write held with phi2 high has no effect until the fall
    cpu_addr = 16'h0000; cpu_wdata = 8'h05; cpu_rw = 1'b0; phi2 = 1'b1;
    repeat (4) @(posedge clk); #1;
    cpu_addr = 16'h4000;
    #1 check("R6 no commit before fall", phys_addr, 20'hA8000);
    cpu_addr = 16'h0000;
    #1 phi2 = 1'b0;
    repeat (2) @(posedge clk); #1;
    probe(16'h4000, 1'b1); check("R5 commit at fall", phys_addr, 20'h14000);

    // R6 read of register with data on bus does not change it
    bus_cycle(16'h0001, 8'h11, 1'b1);
    probe(16'h8000, 1'b1); check("R6 read leaves reg", phys_addr, 20'hFC000);

    // R10 write to $0002 ignored
    bus_cycle(16'h0002, 8'h07, 1'b0);
    probe(16'h4000, 1'b1); check("R10 reg0 untouched", phys_addr, 20'h14000);
    probe(16'h8000, 1'b1); check("R10 reg1 untouched", phys_addr, 20'hFC000);

    // R2 fixed high stays with any registers
    probe(16'hFFFF, 1'b1); check("R2 vector top", phys_addr, 20'hFFFFF);

    // R9 reset again restores identity
    rst = 1'b1;
    repeat (2) @(posedge clk); #1 rst = 1'b0;
    probe(16'h8000, 1'b1); check("R9 after re-reset", phys_addr, 20'h08000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule